// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point numbers (1 sign bit, 8-bit biased exponent, 23-bit fraction with a hidden leading one) and rounds the result to nearest, ties to even. A caller presents both operands together with an operation select and a valid strobe. One clock later the registered result appears with its own valid strobe and four exception flags.

Inside, the operand with the larger magnitude is chosen as the reference. The other significand is shifted right by the exponent gap. Three extra low bits are kept during this shift: two bits that are shifted out and one bit that collects every bit lost below them. A 27-bit signed-magnitude add or subtract follows. The sum is then normalized, either by a one-place right shift on carry or by a left shift over its leading zeros. After rounding, a second one-place normalization handles a carry out of the rounding increment.

Subnormal numbers are not supported. Inputs with a zero exponent field are taken as zero, and results too small for a normal number are replaced by zero.

Top module: `fp32_addsub`

## Requirements
- R1: `out_valid` is high exactly one cycle after each cycle in which `in_valid` is high. Back-to-back requests give back-to-back results. While `in_valid` is low, `result` and the flags keep their last values.
- R2: Rounding is to nearest, ties to even. The first bit below the result LSB decides. When it is 1 and every lower bit is 0, the result is rounded up only if its LSB is 1. For example, 0x3F800000 + 0x33800000 gives 0x3F800000, and 0x3F800001 + 0x33800000 gives 0x3F800002.
- R3: When the exponent gap is larger than 26, the smaller operand affects only the sticky bit. For example, 0x3F800000 + 0x2B800000 gives 0x3F800000 with inexact set, and 0x3F800000 - 0x2B800000 gives 0x3F800000 with inexact set.
- R4: A carry out of an effective addition shifts the sum right by one place and raises the exponent by one. For example, 0x3FC00000 + 0x3FC00000 gives 0x40400000, and 0x4B7FFFFF + 0x3F800000 gives 0x4B800000.
- R5: An effective subtraction is normalized left by its leading-zero count, and the exponent is lowered by that count. For example, 0x3F800000 - 0x3F400000 gives 0x3E800000, and 0x3F800000 - 0x3F7FFFFF gives 0x33800000.
- R6: Subtraction inverts the sign bit of `op_b` (`sub_sel` = 1 subtracts). The result takes the sign of the operand with the larger magnitude. An exact cancellation gives +0 (0x00000000). When both operands are zero, the result is -0 only if both effective signs are negative.
- R7: If rounding carries out of an all-ones significand, the result is renormalized with the exponent raised by one. For example, 0x3F800000 - 0x33000000 gives 0x3F800000.
- R8: Any NaN operand gives 0x7FC00000. Infinities of opposite effective sign give 0x7FC00000 with the invalid flag set. An infinity combined with a finite value, or with an infinity of the same effective sign, gives that infinity.
- R9: A finite result whose exponent reaches 255, either before or after rounding, gives an infinity of the result sign with the overflow and inexact flags set.
- R10: An operand with a zero exponent field counts as zero. A nonzero result whose exponent would be 0 or below is replaced by zero of the result sign, with the underflow and inexact flags set.
- R11: The inexact flag is set exactly when a nonzero bit is lost through rounding, overflow or underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub_sel | input | 1 | 1 computes op_a - op_b, 0 computes op_a + op_b |
| out_valid | output | 1 | Result and flags are new this cycle |
| result | output | 32 | Rounded result |
| exc_invalid | output | 1 | Invalid operation (opposing infinities) |
| exc_overflow | output | 1 | Result overflowed to infinity |
| exc_underflow | output | 1 | Result flushed to zero |
| exc_inexact | output | 1 | Result differs from the exact value |

## Verification
Rounding is tried with operand pairs whose discarded tail is below half, exactly half with an even LSB, exactly half with an odd LSB, and half plus a far sticky bit. These four cases separate a correct ties-to-even rule from plain truncation or from rounding half up. Exponent gaps of 1, 23, 24, 25 and 40 are tried under both addition and subtraction. They show whether the guard bit, the round bit and the collapsed sticky bit each reach the rounding decision. Cancellations down to a single bit tell a correct leading-zero shift from an off-by-one one. Operands built to carry out of the rounding increment, including one at the largest finite value, test the renormalize step and its overflow boundary.

// File: rtl/fp32_pkg.sv
package fp32_pkg;
  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NORM = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;
endpackage

// File: rtl/fp_unpack.sv
module fp_unpack
  import fp32_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output logic                  sign,
  output logic [EXP_W-1:0]      exp_f,
  output logic [FRAC_W:0]       sig,
  output fp_cls_e               cls
);
  logic [EXP_W-1:0]  e_raw;
  logic [FRAC_W-1:0] f_raw;

  assign sign  = word[EXP_W+FRAC_W];
  assign e_raw = word[EXP_W+FRAC_W-1:FRAC_W];
  assign f_raw = word[FRAC_W-1:0];

  always_comb begin
    exp_f = e_raw;
    sig   = {1'b1, f_raw};
    cls   = CLS_NORM;
    if (e_raw == '0) begin
      // subnormal inputs are flushed to zero
      exp_f = '0;
      sig   = '0;
      cls   = CLS_ZERO;
    end else if (&e_raw) begin
      cls = (f_raw == '0) ? CLS_INF : CLS_NAN;
    end
  end
endmodule

// File: rtl/fp_align_shift.sv
module fp_align_shift #(
  parameter int W     = 27,
  parameter int AMT_W = 8
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  localparam int ST = $clog2(W);

  logic [W-1:0] stg [ST+1];
  logic         far;

  assign stg[0] = din;

  // log-depth right shifter; every stage folds lost bits into bit 0
  for (genvar k = 0; k < ST; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stg[k+1] = amt[k]
      ? ((stg[k] >> SH) | {{(W-1){1'b0}}, |stg[k][SH-1:0]})
      : stg[k];
  end

  assign far  = (amt > AMT_W'(W - 1));
  assign dout = far ? {{(W-1){1'b0}}, |din} : stg[ST];
endmodule

// File: rtl/fp_lzc.sv
module fp_lzc #(
  parameter int W  = 27,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int AW     = FRAC_W + 4,
  parameter int EW     = EXP_W + 2
) (
  input  logic                  sign,
  input  logic signed [EW-1:0]  exp_n,
  input  logic [AW-1:0]         sig_n,
  output logic [EXP_W+FRAC_W:0] word,
  output logic                  ovf,
  output logic                  udf,
  output logic                  inx
);
  localparam int P = FRAC_W + 1;
  localparam logic signed [EW-1:0] EMAX = EW'((1 << EXP_W) - 1);
  localparam logic signed [EW-1:0] EONE = EW'(1);

  logic [P-1:0]          keep;
  logic                  guard, tail, up;
  logic [P:0]            rnd;
  logic [FRAC_W-1:0]     frac_r;
  logic signed [EW-1:0]  exp_r;

  assign keep  = sig_n[AW-1:3];
  assign guard = sig_n[2];
  assign tail  = |sig_n[1:0];
  assign up    = guard & (keep[0] | tail);
  assign rnd   = {1'b0, keep} + (P+1)'(up);

  always_comb begin
    if (rnd[P]) begin
      frac_r = rnd[P-1:1];
      exp_r  = exp_n + EW'(1);
    end else begin
      frac_r = rnd[FRAC_W-1:0];
      exp_r  = exp_n;
    end
    ovf  = 1'b0;
    udf  = 1'b0;
    inx  = |sig_n[2:0];
    word = {sign, exp_r[EXP_W-1:0], frac_r};
    if (exp_r >= EMAX) begin
      ovf  = 1'b1;
      inx  = 1'b1;
      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (exp_r < EONE) begin
      udf  = 1'b1;
      inx  = 1'b1;
      word = {sign, {(EXP_W+FRAC_W){1'b0}}};
    end
  end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fp32_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic                  sub_sel,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  exc_invalid,
  output logic                  exc_overflow,
  output logic                  exc_underflow,
  output logic                  exc_inexact
);
  localparam int W  = 1 + EXP_W + FRAC_W;
  localparam int P  = FRAC_W + 1;
  localparam int AW = P + 3;
  localparam int EW = EXP_W + 2;
  localparam int CW = $clog2(AW + 1);
  localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic             sa, sb_raw, sb;
  logic [EXP_W-1:0] ea, eb, e_big, e_sml, diff;
  logic [P-1:0]     sig_a, sig_b, sig_big, sig_sml;
  fp_cls_e          ca, cb;

  fp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
    .word(op_a), .sign(sa), .exp_f(ea), .sig(sig_a), .cls(ca));
  fp_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
    .word(op_b), .sign(sb_raw), .exp_f(eb), .sig(sig_b), .cls(cb));

  assign sb = sb_raw ^ sub_sel;

  // magnitude compare so the difference of significands is never negative
  logic a_ge, s_big, eff_sub;
  assign a_ge    = {ea, sig_a} >= {eb, sig_b};
  assign s_big   = a_ge ? sa : sb;
  assign e_big   = a_ge ? ea : eb;
  assign e_sml   = a_ge ? eb : ea;
  assign sig_big = a_ge ? sig_a : sig_b;
  assign sig_sml = a_ge ? sig_b : sig_a;
  assign diff    = e_big - e_sml;
  assign eff_sub = sa ^ sb;

  logic [AW-1:0] aligned;
  fp_align_shift #(.W(AW), .AMT_W(EXP_W)) u_align (
    .din({sig_sml, 3'b000}), .amt(diff), .dout(aligned));

  logic [AW:0] big_ext, sum;
  assign big_ext = {1'b0, sig_big, 3'b000};
  assign sum     = eff_sub ? (big_ext - {1'b0, aligned}) : (big_ext + {1'b0, aligned});

  logic [CW-1:0] lz;
  fp_lzc #(.W(AW), .CW(CW)) u_lzc (.din(sum[AW-1:0]), .cnt(lz));

  logic [AW-1:0]        n_sig;
  logic signed [EW-1:0] n_exp;
  always_comb begin
    if (sum[AW]) begin
      n_sig = {sum[AW:2], |sum[1:0]};
      n_exp = EW'(e_big) + EW'(1);
    end else begin
      n_sig = sum[AW-1:0] << lz;
      n_exp = EW'(e_big) - EW'(lz);
    end
  end

  logic [W-1:0] packed_w;
  logic         r_ovf, r_udf, r_inx;
  fp_round_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .AW(AW), .EW(EW)) u_round (
    .sign(s_big), .exp_n(n_exp), .sig_n(n_sig),
    .word(packed_w), .ovf(r_ovf), .udf(r_udf), .inx(r_inx));

  // special operand handling and final selection
  logic [W-1:0] nxt_res;
  logic [3:0]   nxt_flg;   // invalid, overflow, underflow, inexact
  always_comb begin
    nxt_res = packed_w;
    nxt_flg = {1'b0, r_ovf, r_udf, r_inx};
    if (ca == CLS_NAN || cb == CLS_NAN) begin
      nxt_res = QNAN;
      nxt_flg = 4'b0000;
    end else if (ca == CLS_INF && cb == CLS_INF) begin
      nxt_res = eff_sub ? QNAN : {sa, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      nxt_flg = {eff_sub, 3'b000};
    end else if (ca == CLS_INF) begin
      nxt_res = {sa, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      nxt_flg = 4'b0000;
    end else if (cb == CLS_INF) begin
      nxt_res = {sb, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      nxt_flg = 4'b0000;
    end else if (ca == CLS_ZERO && cb == CLS_ZERO) begin
      nxt_res = {sa & sb, {(W-1){1'b0}}};
      nxt_flg = 4'b0000;
    end else if (sum == '0) begin
      nxt_res = '0;
      nxt_flg = 4'b0000;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      result        <= '0;
      exc_invalid   <= 1'b0;
      exc_overflow  <= 1'b0;
      exc_underflow <= 1'b0;
      exc_inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        {exc_invalid, exc_overflow, exc_underflow, exc_inexact} <= nxt_flg;
      end
    end
  end
endmodule

// File: rtl/fp32_addsub_chk.sv
module fp32_addsub_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  sub_sel,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] result,
  input logic                  exc_invalid,
  input logic                  exc_overflow,
  input logic                  exc_underflow,
  input logic                  exc_inexact
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic a_nan, a_fin, r_nan, r_inf;
  assign a_nan = (&op_a[W-2:FRAC_W]) && (op_a[FRAC_W-1:0] != '0);
  assign a_fin = !(&op_a[W-2:FRAC_W]);
  assign r_nan = (&result[W-2:FRAC_W]) && (result[FRAC_W-1:0] != '0);
  assign r_inf = (&result[W-2:FRAC_W]) && (result[FRAC_W-1:0] == '0);

  // R1: one-cycle latency
  p_valid_rise_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R1: outputs hold while idle
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(exc_inexact));
  // R6: x - x cancels to +0
  p_self_cancel_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && sub_sel && (op_a == op_b) && a_fin |=> result == '0);
  // R8: NaN propagates
  p_nan_prop_r8: assert property (@(posedge clk) disable iff (rst)
    in_valid && a_nan |=> r_nan);
  p_invalid_nan_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && exc_invalid |-> r_nan);
  // R9: overflow yields infinity and inexact
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && exc_overflow |-> r_inf && exc_inexact);
  // R10: no subnormal output, underflow gives zero
  p_no_denorm_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && (result[W-2:FRAC_W] == '0) |-> result[FRAC_W-1:0] == '0);
  p_udf_zero_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && exc_underflow |-> result[W-2:0] == '0 && exc_inexact);
endmodule

bind fp32_addsub fp32_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .sub_sel(sub_sel), .out_valid(out_valid), .result(result),
  .exc_invalid(exc_invalid), .exc_overflow(exc_overflow),
  .exc_underflow(exc_underflow), .exc_inexact(exc_inexact));

// File: tb/fp32_addsub_tb_top.sv
`timescale 1ns/1ps
module fp32_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        sub_sel = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        exc_invalid, exc_overflow, exc_underflow, exc_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fp32_addsub dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .sub_sel(sub_sel), .out_valid(out_valid), .result(result),
    .exc_invalid(exc_invalid), .exc_overflow(exc_overflow),
    .exc_underflow(exc_underflow), .exc_inexact(exc_inexact));

  function automatic logic [3:0] flg();
    return {exc_invalid, exc_overflow, exc_underflow, exc_inexact};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp_v);
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp_v);
    end
  endtask

  // one request; result sampled at the falling edge after the capturing edge
  task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic sub, input logic [31:0] exp_r, input logic [3:0] exp_f);
    @(negedge clk);
    op_a = a; op_b = b; sub_sel = sub; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({tag, " result"}, result, exp_r);
    chk({tag, " flags"}, {28'd0, flg()}, {28'd0, exp_f});
  endtask

  task automatic t_reset();
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset result", result, 32'd0);
    chk("R1 reset flags", {28'd0, flg()}, 32'd0);
  endtask

  task automatic t_stream_r1();
    @(negedge clk);
    op_a = 32'h3F800000; op_b = 32'h3F800000; sub_sel = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 stream first", result, 32'h40000000);
    op_a = 32'h3FC00000; op_b = 32'h3FC00000;
    @(posedge clk);
    @(negedge clk);
    chk("R1 stream second", result, 32'h40400000);
    chk("R1 stream valid", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0; op_a = 32'h7F800000; sub_sel = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 idle valid", {31'd0, out_valid}, 32'd0);
    chk("R1 idle hold", result, 32'h40400000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 idle hold later", result, 32'h40400000);
  endtask

  task automatic t_round_r2();
    run_op("R2 tie even",  32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 4'b0001);
    run_op("R2 tie odd",   32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 4'b0001);
    run_op("R2 above half",32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 4'b0001);
    run_op("R2 sticky",    32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 4'b0001);
  endtask

  task automatic t_far_r3();
    run_op("R3 far add", 32'h3F800000, 32'h2B800000, 1'b0, 32'h3F800000, 4'b0001);
    run_op("R3 far sub", 32'h3F800000, 32'h2B800000, 1'b1, 32'h3F800000, 4'b0001);
  endtask

  task automatic t_carry_r4();
    run_op("R4 carry 3.0",   32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 4'b0000);
    run_op("R4 carry 2^24",  32'h4B7FFFFF, 32'h3F800000, 1'b0, 32'h4B800000, 4'b0000);
  endtask

  task automatic t_cancel_r5();
    run_op("R5 lz 2",  32'h3F800000, 32'h3F400000, 1'b1, 32'h3E800000, 4'b0000);
    run_op("R5 lz 24", 32'h3F800000, 32'h3F7FFFFF, 1'b1, 32'h33800000, 4'b0000);
  endtask

  task automatic t_sign_r6();
    run_op("R6 x-x",        32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 4'b0000);
    run_op("R6 -x+x",       32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 4'b0000);
    run_op("R6 -0+-0",      32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 4'b0000);
    run_op("R6 -0-+0",      32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 4'b0000);
    run_op("R6 +0-+0",      32'h00000000, 32'h00000000, 1'b1, 32'h00000000, 4'b0000);
    run_op("R6 -2+0.5",     32'hC0000000, 32'h3F000000, 1'b0, 32'hBFC00000, 4'b0000);
    run_op("R6 1-3",        32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, 4'b0000);
  endtask

  task automatic t_renorm_r7();
    run_op("R7 sub renorm", 32'h3F800000, 32'h33000000, 1'b1, 32'h3F800000, 4'b0001);
    run_op("R7 add renorm", 32'h3F7FFFFF, 32'h33000000, 1'b0, 32'h3F800000, 4'b0001);
  endtask

  task automatic t_special_r8();
    run_op("R8 inf-inf",   32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 4'b1000);
    run_op("R8 -inf+inf",  32'hFF800000, 32'h7F800000, 1'b0, 32'h7FC00000, 4'b1000);
    run_op("R8 inf+inf",   32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 4'b0000);
    run_op("R8 inf+1",     32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 4'b0000);
    run_op("R8 1-inf",     32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 4'b0000);
    run_op("R8 nan+1",     32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000, 4'b0000);
  endtask

  task automatic t_overflow_r9();
    run_op("R9 max+max",   32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 4'b0101);
    run_op("R9 round ovf", 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 4'b0101);
    run_op("R9 neg ovf",   32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 4'b0101);
  endtask

  task automatic t_flush_r10();
    run_op("R10 sub in",    32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 4'b0000);
    run_op("R10 two subs",  32'h00000005, 32'h00000003, 1'b0, 32'h00000000, 4'b0000);
    run_op("R10 udf pos",   32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 4'b0011);
    run_op("R10 udf neg",   32'h80800001, 32'h80800000, 1'b1, 32'h80000000, 4'b0011);
  endtask

  task automatic t_inexact_r11();
    run_op("R11 exact ulp", 32'h3F800000, 32'h34000000, 1'b0, 32'h3F800001, 4'b0000);
    run_op("R11 exact 2.0", 32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 4'b0000);
    run_op("R11 lost bit",  32'h3F800000, 32'h2B800000, 1'b0, 32'h3F800000, 4'b0001);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_stream_r1();
    t_round_r2();
    t_far_r3();
    t_carry_r4();
    t_cancel_r5();
    t_sign_r6();
    t_renorm_r7();
    t_special_r8();
    t_overflow_r9();
    t_flush_r10();
    t_inexact_r11();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule